// File: doc/BRIEF.md
# Recursive Rotation Oscillator

This block is a numerically controlled oscillator that keeps a two-component vector in registers and turns it by the fixed angle atan(2^-SHIFT) for every sample taken from its output. One step uses two adders fed by hard-wired arithmetic right shifts, so the block needs no lookup table, no multiplier and no barrel shifter. The x component is the cosine stream and the y component is the sine stream. Both are two's-complement values to be read as fractions of 2^(W-1). The angle step, and so the output frequency for a given clock period, is set only by SHIFT. To produce one output period every T0 seconds at clock period Tc, choose SHIFT near -log2(tan(2*pi*Tc/T0)).

Each step also multiplies the magnitude by sqrt(1 + 2^-2*SHIFT). To keep that growth bounded, the block returns to its stored initial vector and phase after RELOAD_LEN accepted samples. A phase accumulator follows the same steps, giving a quadrant code and a half-turn sign flag without looking at the samples. A load pulse writes a new initial vector and phase. They become both the current state and the stored reload point.

Samples leave on a valid/ready stream. out_valid rises on the first clock after reset and then stays high. A sample counts as accepted on any rising edge where out_valid and out_ready are both high. While out_ready is low, every output holds its value, so a slow consumer loses no sample. The load and initial-value pins are plain control inputs.

Top module: `rot_osc`

## Requirements
- R1: During reset and on the first cycle after it, out_x equals 2^(W-2), out_y equals 0, out_quad equals 0 and out_sign equals 1.
- R2: On each accepted sample that is not a reload, the next pair is x' = x - (y >>> SHIFT) and y' = y + (x >>> SHIFT). Here >>> is an arithmetic right shift, which is floor division by 2^SHIFT.
- R3: While out_valid is high, out_ready is low and load is low, out_x, out_y, out_quad and out_sign do not change on the clock edge.
- R4: On each accepted sample that is not a reload, the phase advances by STEP = round(atan(2^-SHIFT) / (2*pi) * 2^PHASE_W), modulo 2^PHASE_W. out_quad is the top two phase bits: 0 is the first quarter turn, 1 the second, 2 the third and 3 the fourth.
- R5: out_sign is 1 while the phase top bit is 0, which is the first half-turn. It is 0 while that bit is 1.
- R6: The RELOAD_LEN-th accepted sample after the last load or reset is followed by the stored initial x, y and phase, not by a rotated pair. Counting then restarts.
- R7: When load is high on a clock edge, the next outputs are init_x, init_y and the quadrant and sign of init_phase. This holds even when a sample is accepted on that same edge. The reload count restarts at zero.
- R8: The stored reload point is the vector and phase of the most recent load. After reset it is 2^(W-2), 0 and phase 0.
- R9: out_valid is 0 during reset, becomes 1 on the first clock edge after reset is released, and never falls afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Write the initial vector and phase |
| init_x | input | W | Initial cosine component |
| init_y | input | W | Initial sine component |
| init_phase | input | PHASE_W | Phase of the initial vector, in units of 2^-PHASE_W turn |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_x | output | W | Cosine sample |
| out_y | output | W | Sine sample |
| out_quad | output | 2 | Quarter-turn index of the sample's phase |
| out_sign | output | 1 | 1 in the first half-turn, 0 in the second |

## Verification
A wrong vector register shows up at the ports on the very next accepted sample. Because later samples are built from earlier ones, the error then persists and spreads until the next reload, so comparing every sample catches it at once. A phase or reload-count fault can stay hidden until a quadrant boundary or the reload point. For that reason the sweeps run through several full reload periods and several half-turn crossings, with back-pressure in both steady and irregular patterns.

// File: rtl/rot_osc_pkg.sv
package rot_osc_pkg;

  typedef enum logic [1:0] {
    Q_FIRST  = 2'd0,
    Q_SECOND = 2'd1,
    Q_THIRD  = 2'd2,
    Q_FOURTH = 2'd3
  } quad_e;

  // Phase increment per step, in units of 2^-pw turn. Uses a series for
  // atan(t) with t = 2^-shift; valid for shift >= 1 and pw <= 32.
  function automatic int phase_step(input int shift, input int pw);
    real t;
    real term;
    real acc;
    t    = 1.0 / (2.0 ** shift);
    term = t;
    acc  = 0.0;
    for (int k = 0; k < 64; k++) begin
      if (k % 2 == 0) acc = acc + term / (2.0 * k + 1.0);
      else            acc = acc - term / (2.0 * k + 1.0);
      term = term * t * t;
    end
    return $rtoi(acc / (2.0 * 3.14159265358979323846) * (2.0 ** pw) + 0.5);
  endfunction

endpackage

// File: rtl/rot_osc_stage.sv
module rot_osc_stage #(
  parameter int W     = 32,
  parameter int SHIFT = 10
) (
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);

  logic signed [W-1:0] x_sh;
  logic signed [W-1:0] y_sh;

  generate
    if (SHIFT >= W) begin : g_full
      assign x_sh = {W{x_i[W-1]}};
      assign y_sh = {W{y_i[W-1]}};
    end else begin : g_wired
      assign x_sh = {{SHIFT{x_i[W-1]}}, x_i[W-1:SHIFT]};
      assign y_sh = {{SHIFT{y_i[W-1]}}, y_i[W-1:SHIFT]};
    end
  endgenerate

  assign x_o = x_i - y_sh;
  assign y_o = y_i + x_sh;

endmodule

// File: rtl/rot_osc_phase.sv
module rot_osc_phase #(
  parameter int PHASE_W    = 32,
  parameter int STEP       = 1,
  parameter int RELOAD_LEN = 4096,
  parameter int CNT_W      = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  logic [PHASE_W-1:0] init_phase,
  output logic [PHASE_W-1:0] phase_o,
  output logic               wrap_o
);

  localparam logic [CNT_W-1:0]   LAST   = CNT_W'(RELOAD_LEN - 1);
  localparam logic [PHASE_W-1:0] STEP_V = PHASE_W'(STEP);

  logic [PHASE_W-1:0] ph_q;
  logic [PHASE_W-1:0] ph_init_q;
  logic [CNT_W-1:0]   cnt_q;

  assign wrap_o  = adv && (cnt_q == LAST);
  assign phase_o = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= '0;
      ph_init_q <= '0;
      cnt_q     <= '0;
    end else if (load) begin
      ph_q      <= init_phase;
      ph_init_q <= init_phase;
      cnt_q     <= '0;
    end else if (adv) begin
      if (wrap_o) begin
        ph_q  <= ph_init_q;
        cnt_q <= '0;
      end else begin
        ph_q  <= ph_q + STEP_V;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  a_r4_phase_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(ph_q));

  a_r6_phase_restored: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !load) |=> (ph_q == $past(ph_init_q) && cnt_q == '0));

endmodule

// File: rtl/rot_osc.sv
module rot_osc #(
  parameter int W          = 32,
  parameter int SHIFT      = 10,
  parameter int PHASE_W    = 32,
  parameter int RELOAD_LEN = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [W-1:0]       init_x,
  input  logic [W-1:0]       init_y,
  input  logic [PHASE_W-1:0] init_phase,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       out_x,
  output logic [W-1:0]       out_y,
  output logic [1:0]         out_quad,
  output logic               out_sign
);
  import rot_osc_pkg::*;

  localparam int          STEP  = phase_step(SHIFT, PHASE_W);
  localparam int          CNT_W = $clog2(RELOAD_LEN + 1);
  localparam logic [W-1:0] X_DEF = {2'b01, {(W-2){1'b0}}};

  logic         valid_q;
  logic [W-1:0] x_q, y_q, x_init_q, y_init_q;
  logic [W-1:0] x_nx, y_nx;
  logic [PHASE_W-1:0] phase;
  logic         adv, wrap;
  quad_e        quad;

  assign adv = valid_q && out_ready;

  rot_osc_stage #(.W(W), .SHIFT(SHIFT)) u_stage (
    .x_i (x_q),
    .y_i (y_q),
    .x_o (x_nx),
    .y_o (y_nx)
  );

  rot_osc_phase #(
    .PHASE_W    (PHASE_W),
    .STEP       (STEP),
    .RELOAD_LEN (RELOAD_LEN),
    .CNT_W      (CNT_W)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .adv        (adv),
    .init_phase (init_phase),
    .phase_o    (phase),
    .wrap_o     (wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      x_q      <= X_DEF;
      y_q      <= '0;
      x_init_q <= X_DEF;
      y_init_q <= '0;
    end else begin
      valid_q <= 1'b1;
      if (load) begin
        x_q      <= init_x;
        y_q      <= init_y;
        x_init_q <= init_x;
        y_init_q <= init_y;
      end else if (wrap) begin
        x_q <= x_init_q;
        y_q <= y_init_q;
      end else if (adv) begin
        x_q <= x_nx;
        y_q <= y_nx;
      end
    end
  end

  assign quad      = quad_e'(phase[PHASE_W-1 -: 2]);
  assign out_valid = valid_q;
  assign out_x     = x_q;
  assign out_y     = y_q;
  assign out_quad  = quad;
  assign out_sign  = (quad == Q_FIRST) || (quad == Q_SECOND);

  a_r9_valid_stays: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=>
      ($stable(out_x) && $stable(out_y) && $stable(out_quad)));

  a_r7_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_x == $past(init_x) && out_y == $past(init_y)));

  a_r6_reload_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load) |=> (out_x == $past(x_init_q) && out_y == $past(y_init_q)));

endmodule

// File: tb/rot_osc_bench.sv
module rot_osc_bench;

  localparam int W     = 32;
  localparam int S     = 3;
  localparam int PW    = 32;
  localparam int LEN   = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [W-1:0]  init_x = '0;
  logic [W-1:0]  init_y = '0;
  logic [PW-1:0] init_phase = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_x, out_y;
  logic [1:0]    out_quad;
  logic          out_sign;

  always #4 clk = ~clk;

  rot_osc #(.W(W), .SHIFT(S), .PHASE_W(PW), .RELOAD_LEN(LEN)) u_rot_osc (
    .clk(clk), .rst_n(rst_n), .load(load), .init_x(init_x), .init_y(init_y),
    .init_phase(init_phase), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_quad(out_quad), .out_sign(out_sign)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  longint m_x, m_y, m_ix, m_iy;
  longint m_ph, m_ip, m_step;
  int     m_cnt;
  bit     m_valid;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint fdiv(input longint a);
    longint d, q;
    d = longint'(1) << S;
    q = a / d;
    if (a < 0 && q * d != a) q = q - 1;
    return q;
  endfunction

  function automatic longint wrap_w(input longint v);
    logic [W-1:0] t;
    t = v[W-1:0];
    return longint'($signed(t));
  endfunction

  task automatic compare(input string ctx);
    chk(out_valid == m_valid, {ctx, " R9 valid"}, longint'(out_valid), longint'(m_valid));
    chk(longint'($signed(out_x)) == m_x, {ctx, " R2 x"}, longint'($signed(out_x)), m_x);
    chk(longint'($signed(out_y)) == m_y, {ctx, " R2 y"}, longint'($signed(out_y)), m_y);
    chk(longint'(out_quad) == ((m_ph >> (PW - 2)) & 3), {ctx, " R4 quad"},
        longint'(out_quad), (m_ph >> (PW - 2)) & 3);
    chk(out_sign == !m_ph[PW-1], {ctx, " R5 sign"}, longint'(out_sign), longint'(!m_ph[PW-1]));
  endtask

  task automatic model_reset();
    m_x = longint'(1) << (W - 2); m_y = 0; m_ix = m_x; m_iy = 0;
    m_ph = 0; m_ip = 0; m_cnt = 0; m_valid = 1'b0;
  endtask

  // one clock: check at the falling edge, drive, let the edge pass, update model
  task automatic step(input bit rdy, input bit ld, input longint ix, input longint iy,
                      input longint ip, input string ctx);
    longint nx, ny;
    @(negedge clk);
    compare(ctx);
    out_ready  = rdy;
    load       = ld;
    init_x     = ix[W-1:0];
    init_y     = iy[W-1:0];
    init_phase = ip[PW-1:0];
    @(posedge clk);
    #1;
    if (ld) begin
      m_x = wrap_w(ix); m_y = wrap_w(iy); m_ix = m_x; m_iy = m_y;
      m_ph = ip & 64'hFFFF_FFFF; m_ip = m_ph; m_cnt = 0;
    end else if (m_valid && rdy) begin
      if (m_cnt == LEN - 1) begin
        m_x = m_ix; m_y = m_iy; m_ph = m_ip; m_cnt = 0;
      end else begin
        nx = wrap_w(m_x - fdiv(m_y));
        ny = wrap_w(m_y + fdiv(m_x));
        m_x = nx; m_y = ny;
        m_ph = (m_ph + m_step) & 64'hFFFF_FFFF;
        m_cnt++;
      end
    end
    m_valid = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit [7:0] lfsr;
    m_step = longint'($rtoi($atan(1.0 / (2.0 ** S)) / (2.0 * 3.14159265358979323846)
                           * (2.0 ** PW) + 0.5));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 and R9: reset state
    compare("reset R1");
    rst_n = 1'b1;
    m_valid = 1'b1;

    // R2 R4 R5 R6: continuous acceptance across two reload points
    for (int i = 0; i < 130; i++) step(1'b1, 1'b0, 0, 0, 0, "stream R6");

    // R3: irregular back-pressure
    lfsr = 8'h5B;
    for (int i = 0; i < 150; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], 1'b0, 0, 0, 0, "stall R3");
    end

    // R7: load while a sample is accepted, new phase in the second half-turn
    step(1'b1, 1'b1, -(longint'(1) << 29), longint'(1) << 28, 64'h8000_0000, "load R7");
    // R8: reload returns to the loaded point, alternating ready
    for (int i = 0; i < 130; i++) step(i[0], 1'b0, 0, 0, 0, "reload R8");

    // R7: load with ready low, phase near the wrap of the accumulator
    step(1'b0, 1'b1, longint'(1) << 29, -(longint'(1) << 27), 64'hFF00_0000, "load idle R7");
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 0, 0, 0, "wrap R4");

    // R8: reset restores the default reload point
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    model_reset();
    @(negedge clk);
    compare("re-reset R1");
    rst_n = 1'b1;
    m_valid = 1'b1;
    for (int i = 0; i < 65; i++) step(1'b1, 1'b0, 0, 0, 0, "default R8");

    finish_run();
  end

endmodule